// File: doc/BRIEF.md
# Reduction Constant Segment Extractor

This block supplies the constant pieces that double-precision argument reduction needs. It takes an IEEE double operand and a segment number. It returns, as a double, a 53-bit slice of the binary expansion of 2/π. The slice starts at a bit offset that grows with the operand's exponent and with the segment number. Software multiplies the operand by successive slices (segment 0, 1, 2, …) to reduce a large angle without losing precision. The bits of 2/π are held in a built-in table of 37 words of 32 bits, covering the first 1184 fractional bits.

The datapath has three parts, all combinational:

- **Window stage.** Forms the offset and reads three consecutive table words. It shifts them to pull out the 53-bit slice.
- **Pack stage.** Normalises the slice with a leading-zero count and applies the power-of-two scale. It rounds to a subnormal when the scaled value falls below the normal range.
- **Select.** Chooses between a NaN passthrough, a zero for an out-of-range segment, and the packed value.

The selected value is registered once. A two-state output controller has the states `ST_IDLE` and `ST_SHOW`. From either state it moves to `ST_SHOW` when `in_valid` is high and to `ST_IDLE` when it is low. `out_valid` is high exactly in `ST_SHOW`. The result register loads only on cycles with `in_valid` high.

Top module: `rc_slice_unit`

## Requirements
- R1: Only `seg[4:0]` selects the segment. Higher bits have no effect, so -32 behaves as segment 0, -1 as segment 31, and 0x22 as segment 2.
- R2: With biased exponent E = `src[62:52]` ≤ 1077, the slice starts at fractional bit 53·segment of 2/π. Bit 0 is the MSB of the first table word, 0xA2F9836E. The result is that 53-bit integer times 2^(−53−offset). Examples: src 0.0 with segment 0 gives 0x3FE45F306DC9C882, and with segment 2 gives 0x394A6EE06DB14ACC.
- R3: With E > 1077, the offset grows by E − 1077. For E = 1607, segment 0 gives 0x1EC8135A2FBF209C and segment 2 gives 0x181272117E2EF7E4.
- R4: With E ≥ 1968, the scale exponent is raised by 128. For E = 1968, segment 0 gives 0x10374F463F669E5F. Infinity of either sign with segment 0 gives 0x0B43DD63F5F2F8BD.
- R5: When (offset >> 5) + 2 ≥ 37, the result is +0.0. Examples: E ≤ 1077 with segment ≥ 22, E = 1607 with segment 12, and E = 1968 with segment 5.
- R6: A NaN operand is returned with bit 51 forced to 1, keeping its sign and payload. For example, 0x7FF0000000000001 becomes 0x7FF8000000000001.
- R7: For every non-NaN operand the sign bit of `src` is ignored, and the result sign bit is 0.
- R8: A scaled value below the normal range is returned as a subnormal rounded to nearest, ties to even. A value below half the smallest subnormal becomes +0.0.
- R9: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. `result` carries that input's value and keeps it while `in_valid` stays low.
- R10: Synchronous reset `rst` clears `out_valid`, even when `in_valid` is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and segment are valid this cycle |
| src | input | 64 | IEEE double operand |
| seg | input | 32 | Segment select (low five bits used) |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Scaled 2/π slice as an IEEE double |

## Verification
The hardest outputs to reach are subnormal results and the rounding that comes with them. They occur only in a narrow band of offsets near 1022–1075, where the slice is still in range but its scale falls below the normal limit. The stimulus sweeps the exponent one step at a time from 1077 upward at segments 19 and 20. This walks the offset through the band and on into the flush-to-zero and out-of-range cases. Expected values come from a reference that reads the slice bit by bit and scales it in two floating-point multiplications, so only the last one rounds.

// File: rtl/rc_slice_pkg.sv
package rc_slice_pkg;

    localparam int DBL_W      = 64;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int SLICE_W    = FRAC_W + 1;
    localparam int SEL_W      = 5;
    localparam int WORD_W     = 32;
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int ROM_WORDS  = 37;
    localparam int OFF_W      = 12;
    localparam int IDX_W      = OFF_W - BIT_W;
    localparam int ADDR_W     = IDX_W + 1;
    localparam int EXP_BIAS   = 1023;
    localparam int EXP_KNEE   = 1077;
    localparam int BOOST_EXP  = 1968;
    localparam int BOOST      = 128;
    localparam int SEG_STRIDE = 53;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } out_state_e;

    // Fractional bits of 2/pi, most significant word first.
    function automatic logic [WORD_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] w;
        case (a)
            8'd0:  w = 32'ha2f9836e;  8'd1:  w = 32'h4e441529;
            8'd2:  w = 32'hfc2757d1;  8'd3:  w = 32'hf534ddc0;
            8'd4:  w = 32'hdb629599;  8'd5:  w = 32'h3c439041;
            8'd6:  w = 32'hfe5163ab;  8'd7:  w = 32'hdebbc561;
            8'd8:  w = 32'hb7246e3a;  8'd9:  w = 32'h424dd2e0;
            8'd10: w = 32'h06492eea;  8'd11: w = 32'h09d1921c;
            8'd12: w = 32'hfe1deb1c;  8'd13: w = 32'hb129a73e;
            8'd14: w = 32'he88235f5;  8'd15: w = 32'h2ebb4484;
            8'd16: w = 32'he99c7026;  8'd17: w = 32'hb45f7e41;
            8'd18: w = 32'h3991d639;  8'd19: w = 32'h835339f4;
            8'd20: w = 32'h9c845f8b;  8'd21: w = 32'hbdf9283b;
            8'd22: w = 32'h1ff897ff;  8'd23: w = 32'hde05980f;
            8'd24: w = 32'hef2f118b;  8'd25: w = 32'h5a0a6d1f;
            8'd26: w = 32'h6d367ecf;  8'd27: w = 32'h27cb09b7;
            8'd28: w = 32'h4f463f66;  8'd29: w = 32'h9e5fea2d;
            8'd30: w = 32'h7527bac7;  8'd31: w = 32'hebe5f17b;
            8'd32: w = 32'h3d0739f7;  8'd33: w = 32'h8a5292ea;
            8'd34: w = 32'h6bfb5fb1;  8'd35: w = 32'h1f8d5d08;
            8'd36: w = 32'h56033046;
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rc_slice_window.sv
module rc_slice_window
    import rc_slice_pkg::*;
(
    input  logic [EXP_W-1:0]   exp_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [OFF_W-1:0]   off_o,
    output logic               oob_o,
    output logic [SLICE_W-1:0] slice_o
);

    localparam int WIN_W = 3 * WORD_W;

    logic [OFF_W-1:0]  exp_part;
    logic [OFF_W-1:0]  seg_part;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] a0;
    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  win_sh;

    always_comb begin
        exp_part = (exp_i > EXP_W'(EXP_KNEE)) ? OFF_W'(exp_i - EXP_W'(EXP_KNEE)) : '0;
        seg_part = OFF_W'(sel_i) * OFF_W'(SEG_STRIDE);
        off_o    = exp_part + seg_part;
        idx      = off_o[OFF_W-1:BIT_W];
        a0       = ADDR_W'(idx);
        oob_o    = a0 >= ADDR_W'(ROM_WORDS - 2);
        win      = {rom_word(a0), rom_word(a0 + ADDR_W'(1)), rom_word(a0 + ADDR_W'(2))};
        win_sh   = win << off_o[BIT_W-1:0];
        slice_o  = win_sh[WIN_W-1 -: SLICE_W];
    end

endmodule

// File: rtl/rc_slice_pack.sv
module rc_slice_pack
    import rc_slice_pkg::*;
(
    input  logic [SLICE_W-1:0] slice_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic               boost_i,
    output logic [DBL_W-1:0]   bits_o
);

    localparam int LZ_W  = $clog2(SLICE_W + 1);
    localparam int BE_W  = OFF_W + 2;
    localparam int PAD_W = 64;
    localparam int SH_W  = $clog2(PAD_W);
    localparam int EXT_W = SLICE_W + PAD_W;

    logic [LZ_W-1:0]        lz;
    logic [SLICE_W-1:0]     norm;
    logic signed [BE_W-1:0] be;
    logic [BE_W-1:0]        shamt;
    logic [SH_W-1:0]        sh;
    logic [EXT_W-1:0]       ext;
    logic [SLICE_W-1:0]     q;
    logic                   guard;
    logic                   sticky;
    logic                   up;

    always_comb begin
        lz = LZ_W'(SLICE_W);
        for (int i = 0; i < SLICE_W; i++) begin
            if (slice_i[i]) lz = LZ_W'(SLICE_W - 1 - i);
        end
        norm  = slice_i << lz;
        be    = BE_W'(EXP_BIAS - 1) - BE_W'(lz) - BE_W'(off_i)
              + (boost_i ? BE_W'(BOOST) : BE_W'(0));
        shamt = BE_W'(1) - be;
        sh    = (shamt > BE_W'(PAD_W - 1)) ? SH_W'(PAD_W - 1) : shamt[SH_W-1:0];
        ext   = {norm, {PAD_W{1'b0}}} >> sh;
        q      = ext[EXT_W-1 -: SLICE_W];
        guard  = ext[PAD_W-1];
        sticky = |ext[PAD_W-2:0];
        up     = guard & (sticky | q[0]);

        if (slice_i == '0) begin
            bits_o = '0;
        end else if (be > 0) begin
            bits_o = {1'b0, be[EXP_W-1:0], norm[FRAC_W-1:0]};
        end else begin
            bits_o = DBL_W'(q + SLICE_W'(up));
        end
    end

endmodule

// File: rtl/rc_slice_unit.sv
module rc_slice_unit
    import rc_slice_pkg::*;
#(
    parameter int SEG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DBL_W-1:0] src,
    input  logic [SEG_W-1:0] seg,
    output logic             out_valid,
    output logic [DBL_W-1:0] result
);

    localparam logic [DBL_W-1:0] QUIET_BIT = DBL_W'(1) << (FRAC_W - 1);

    out_state_e         state_q;
    out_state_e         state_d;
    logic [EXP_W-1:0]   src_exp;
    logic               is_nan;
    logic               boost;
    logic [OFF_W-1:0]   off;
    logic               oob;
    logic [SLICE_W-1:0] slice;
    logic [DBL_W-1:0]   packed_val;
    logic [DBL_W-1:0]   next_val;
    logic               seg_hi_unused;

    assign seg_hi_unused = ^seg[SEG_W-1:SEL_W];
    assign src_exp       = src[DBL_W-2 -: EXP_W];
    assign is_nan        = (&src_exp) & (|src[FRAC_W-1:0]);
    assign boost         = src_exp >= EXP_W'(BOOST_EXP);

    rc_slice_window u_window (
        .exp_i   (src_exp),
        .sel_i   (seg[SEL_W-1:0]),
        .off_o   (off),
        .oob_o   (oob),
        .slice_o (slice)
    );

    rc_slice_pack u_pack (
        .slice_i (slice),
        .off_i   (off),
        .boost_i (boost),
        .bits_o  (packed_val)
    );

    always_comb begin
        if (is_nan)   next_val = src | QUIET_BIT;
        else if (oob) next_val = '0;
        else          next_val = packed_val;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= next_val;
    end

    always_comb out_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/rc_slice_unit_chk.sv
module rc_slice_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] src,
    input logic [31:0] seg,
    input logic        out_valid,
    input logic [63:0] result
);

    logic nan_in;
    assign nan_in = (&src[62:52]) & (|src[51:0]);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R6
    nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nan_in) |=> result == ($past(src) | 64'h0008_0000_0000_0000));

    // R7
    sign_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !nan_in) |=> !result[63]);

    // R5
    oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !nan_in && src[62:52] <= 11'd1077 && seg[4:0] >= 5'd22) |=> result == 64'd0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind rc_slice_unit rc_slice_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src       (src),
    .seg       (seg),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/rc_slice_unit_bench.sv
module rc_slice_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [31:0] seg = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q[$];
    int          stamp_q[$];
    string       tag_q[$];

    localparam logic [31:0] TBL [37] = '{
        32'ha2f9836e, 32'h4e441529, 32'hfc2757d1, 32'hf534ddc0, 32'hdb629599,
        32'h3c439041, 32'hfe5163ab, 32'hdebbc561, 32'hb7246e3a, 32'h424dd2e0,
        32'h06492eea, 32'h09d1921c, 32'hfe1deb1c, 32'hb129a73e, 32'he88235f5,
        32'h2ebb4484, 32'he99c7026, 32'hb45f7e41, 32'h3991d639, 32'h835339f4,
        32'h9c845f8b, 32'hbdf9283b, 32'h1ff897ff, 32'hde05980f, 32'hef2f118b,
        32'h5a0a6d1f, 32'h6d367ecf, 32'h27cb09b7, 32'h4f463f66, 32'h9e5fea2d,
        32'h7527bac7, 32'hebe5f17b, 32'h3d0739f7, 32'h8a5292ea, 32'h6bfb5fb1,
        32'h1f8d5d08, 32'h56033046};

    rc_slice_unit u_rc_slice_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src       (src),
        .seg       (seg),
        .out_valid (out_valid),
        .result    (result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic pi_bit(input int k);
        if (k / 32 >= 37) return 1'b0;
        return TBL[k / 32][31 - (k % 32)];
    endfunction

    // Reference built from R2-R8: bitwise slice read, two-step scaling.
    function automatic logic [63:0] model(input logic [63:0] s, input logic [31:0] g);
        int e;
        int off;
        int sc;
        longint unsigned m;
        real v;
        e = int'(s[62:52]);
        if (e == 2047 && s[51:0] != 0) return s | 64'h0008_0000_0000_0000;
        off = ((e > 1077) ? e - 1077 : 0) + 53 * int'(g[4:0]);
        if ((off >> 5) + 2 >= 37) return 64'd0;
        m = 0;
        for (int i = 0; i < 53; i++) m = (m << 1) | longint'(pi_bit(off + i));
        sc = -53 - off + ((e >= 1968) ? 128 : 0);
        v = real'(m);
        if (sc < -600) v = (v * (2.0 ** (-600))) * (2.0 ** (sc + 600));
        else           v = v * (2.0 ** sc);
        return $realtobits(v);
    endfunction

    task automatic apply(input logic [63:0] s, input logic [31:0] g,
                         input logic [63:0] e, input string tag);
        @(negedge clk);
        src      = s;
        seg      = g;
        in_valid = 1'b1;
        exp_q.push_back(e);
        stamp_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 output without input", result, 64'd0);
                end else begin
                    logic [63:0] e;
                    int st;
                    string t;
                    e  = exp_q.pop_front();
                    st = stamp_q.pop_front();
                    t  = tag_q.pop_front();
                    check(result === e, t, result, e);
                    check(cyc == st + 1, "R9 latency", 64'(cyc), 64'(st + 1));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] f345;
        f345 = $realtobits(345.435);

        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // R2 base window
        apply(64'd0, 32'd0, 64'h3FE45F306DC9C882, "R2 zero seg0");
        apply(64'd0, 32'd2, 64'h394A6EE06DB14ACC, "R2 zero seg2");
        apply(f345,  32'd2, 64'h394A6EE06DB14ACC, "R2 345.435 seg2");
        // R1 upper select bits ignored
        apply(f345,  32'hFFFF_FFE0, 64'h3FE45F306DC9C882, "R1 seg -32");
        apply(64'd0, 32'hFFFF_FFFF, 64'd0, "R1 seg -1");
        apply(64'd0, 32'h0000_0022, 64'h394A6EE06DB14ACC, "R1 seg 0x22");
        // R3 exponent-driven offset
        apply(64'h6470000000000000, 32'd0, 64'h1EC8135A2FBF209C, "R3 e1607 seg0");
        apply(64'h6470000000000000, 32'd2, 64'h181272117E2EF7E4, "R3 e1607 seg2");
        // R4 boosted scale
        apply(64'h7B00000000000000, 32'd0, 64'h10374F463F669E5F, "R4 e1968 seg0");
        apply(64'h7B00000000000000, 32'd2, 64'h098F2F8BD9E839CE, "R4 e1968 seg2");
        apply(64'h7FF0000000000000, 32'd0, 64'h0B43DD63F5F2F8BD, "R4 +inf seg0");
        idle(2);
        // R5 out-of-range
        apply(64'd0, 32'd22, 64'd0, "R5 zero seg22");
        apply(64'h6470000000000000, 32'd12, 64'd0, "R5 e1607 seg12");
        apply(64'h7B00000000000000, 32'd5, 64'd0, "R5 e1968 seg5");
        apply(64'h6470000000000000, 32'd11, model(64'h6470000000000000, 32'd11), "R5 e1607 seg11 edge");
        apply(64'h7B00000000000000, 32'd4, model(64'h7B00000000000000, 32'd4), "R5 e1968 seg4 edge");
        // R6 NaN passthrough
        apply(64'h7FF0000000000001, 32'd0, 64'h7FF8000000000001, "R6 snan");
        apply(64'h7FF8000000000000, 32'd7, 64'h7FF8000000000000, "R6 qnan");
        apply(64'hFFF0000000000005, 32'd3, 64'hFFF8000000000005, "R6 neg snan");
        // R7 sign ignored
        apply(64'h8000000000000000, 32'd0, 64'h3FE45F306DC9C882, "R7 -0.0 seg0");
        apply(f345 | 64'h8000000000000000, 32'd2, 64'h394A6EE06DB14ACC, "R7 -345.435 seg2");
        apply(64'hFFF0000000000000, 32'd0, 64'h0B43DD63F5F2F8BD, "R7 -inf seg0");
        idle(3);

        // R9 hold while idle
        held = result;
        idle(3);
        @(posedge clk); #2;
        check(out_valid === 1'b0, "R9 idle out_valid", 64'(out_valid), 64'd0);
        check(result === held, "R9 idle hold", result, held);

        // R8 subnormal band and flush to zero
        for (int k = 0; k <= 83; k++) begin
            logic [63:0] s;
            s = {1'b0, 11'(1077 + k), 52'h5_A5A5_0F0F_3C3C};
            apply(s, 32'd19, model(s, 32'd19), "R8 seg19 sweep");
            apply(s, 32'd20, model(s, 32'd20), "R8 seg20 sweep");
        end
        idle(2);

        // R2 R3 R4 R5 general sweep, with upper select bits set (R1)
        foreach (TBL[j]) begin
            int ev;
            ev = (j * 57) % 2047;
            for (int g = 0; g < 32; g += 3) begin
                logic [63:0] s;
                logic [31:0] gg;
                s  = {j[0], 11'(ev), 52'(64'h9_1234_5678_9ABC * (j + 1))};
                gg = {27'(j * 1234567), 5'(g)};
                apply(s, gg, model(s, gg), "R3 R4 R5 sweep");
            end
        end
        foreach (TBL[j]) begin
            logic [63:0] s;
            s = {1'b0, 11'(1968 + j * 2), 52'd77};
            apply(s, 32'(j % 6), model(s, 32'(j % 6)), "R4 boost sweep");
        end
        idle(5);
        check(exp_q.size() == 0, "R9 missing outputs", 64'(exp_q.size()), 64'd0);

        // R10 reset wins over in_valid
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        src      = 64'd0;
        @(negedge clk);
        check(out_valid === 1'b0, "R10 reset with in_valid", 64'(out_valid), 64'd0);
        in_valid = 1'b0;
        rst      = 1'b0;
        idle(2);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule